// File: doc/BRIEF.md
# Vector Load-Store Address Sequencer

This block expands a single vector memory instruction into a series of per-element memory requests. It is given a start address, an addressing mode, a runtime element count and a per-element write-enable mask. It then presents one request per element on a valid/ready memory port, in ascending element order. There are three address patterns. Contiguous 64-bit words use a step of 8 bytes. A fixed stride comes from a scalar operand. The indexed mode gathers on a load and scatters on a store, and it adds an offset taken from an index vector to the base. The index vector is read one element at a time through a lookup port keyed by the request's element number.

For loads, the memory returns responses in order after a start-up delay. The sequencer writes each returned word into a 64-entry element buffer at the matching element slot, but only where the mask allows it. A separate read port exposes the buffer. A one-cycle completion pulse marks the end of the operation: after the last store request is accepted, or after the last load response has arrived. The control is a four-state machine. IDLE waits for `start`. ISSUE walks the elements. DRAIN waits for outstanding load responses. FIN raises the completion pulse. The transitions are: launch (IDLE to ISSUE), empty (IDLE to FIN when the count is zero), store-end (ISSUE to FIN), load-end (ISSUE to DRAIN), drained (DRAIN to FIN) and retire (FIN to IDLE).

Top module: `vls_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `req_valid` are all low.
- R2: With `mode` = 2'b00 (contiguous), element i is requested at `base + 8*i`, modulo 2^32.
- R3: With `mode` = 2'b01 (strided), element i is requested at `base + i*stride`, modulo 2^32.
- R4: With `mode[1]` = 1 (indexed), element i is requested at `base + idx_value`, where `idx_value` is the index entry for the element shown on `req_elem`. This holds for loads and stores alike.
- R5: Exactly one request is issued per element, with `req_elem` running 0, 1, 2, … in order. While `req_ready` is low, the same request (address and element) is held.
- R6: A `vlen` above 64 is treated as 64.
- R7: A `vlen` of zero issues no request, and `done` is high in the cycle right after the cycle in which `start` is sampled.
- R8: Every element is issued, and `req_mask` carries that element's bit of `mask`. A load writes the buffer only for elements whose mask bit is 1. Entries for masked-off elements keep their old contents.
- R9: The k-th load response (counting from 0) is stored in buffer entry k. `rd_data` shows entry `rd_elem` combinationally.
- R10: Store requests carry `req_write` = 1. `done` is high for one cycle, in the cycle after the last request is accepted.
- R11: Load requests carry `req_write` = 0. `done` is high for one cycle, in the cycle after the last response is taken.
- R12: A `start` that arrives while `busy` is high is ignored. It has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (sampled while idle) |
| mode | input | 2 | 00 contiguous, 01 strided, 1x indexed |
| is_store | input | 1 | 1 = store/scatter, 0 = load/gather |
| base | input | 32 | Base byte address |
| stride | input | 32 | Byte stride for strided mode |
| vlen | input | 8 | Requested element count |
| mask | input | 64 | Per-element enable, bit i for element i |
| idx_value | input | 32 | Index entry for element `req_elem` |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Element byte address |
| req_write | output | 1 | 1 = write request |
| req_mask | output | 1 | Mask bit of this element |
| req_elem | output | 6 | Element number of the request |
| rsp_valid | input | 1 | Load response present |
| rsp_data | input | 64 | Load response word |
| rd_elem | input | 6 | Buffer read select |
| rd_data | output | 64 | Buffer entry `rd_elem` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first request appears in the cycle after `start` is sampled, and each later one follows the edge at which the previous one was accepted. The bench therefore logs requests only at edges where valid and ready are both high, and it compares the logged requests in order, whatever the stall pattern was. A store's `done` is due one edge after its last acceptance. A load's `done` is due thirteen edges after its last acceptance: the modelled memory takes twelve edges, and the state machine adds one. A zero-length operation finishes one edge after `start`. The bench records the edge number of every acceptance and of every `done`, and it compares the differences. It reads buffer contents only after `done`, with `rd_elem` driven on the falling edge.

// File: rtl/vls_pkg.sv
package vls_pkg;
    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/vls_fsm.sv
module vls_fsm
    import vls_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_store,
    input  logic [VL_W-1:0] vlen,
    input  logic            accept,
    input  logic            last_issue,
    input  logic            rsp_fire,
    input  logic            last_rsp,
    output logic            capture,
    output logic            store_q,
    output logic [VL_W-1:0] vl_q,
    output seq_state_e      state,
    output logic            req_valid,
    output logic            busy,
    output logic            done
);
    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    seq_state_e      nxt;
    logic [VL_W-1:0] vl_eff;

    assign vl_eff  = (vlen > VL_CAP) ? VL_CAP : vlen;
    assign capture = (state == ST_IDLE) && start;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (vl_eff == '0) ? ST_FIN : ST_ISSUE;
            ST_ISSUE: if (accept && last_issue) nxt = store_q ? ST_FIN : ST_DRAIN;
            ST_DRAIN: if (rsp_fire && last_rsp) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vl_q    <= '0;
            store_q <= 1'b0;
        end else begin
            state <= nxt;
            if (capture) begin
                vl_q    <= vl_eff;
                store_q <= is_store;
            end
        end
    end

    always_comb begin
        req_valid = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_ISSUE: req_valid = 1'b1;
            ST_DRAIN: ;
            ST_FIN:   done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    a_r6_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (vl_q <= VL_CAP));
    a_r12_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && start) |=> (vl_q == $past(vl_q)) && (store_q == $past(store_q)));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int EW         = 6,
    parameter int ELEM_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  amode_e            amode_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic              valid,
    input  logic              accept,
    input  logic [ADDR_W-1:0] idx_value,
    output logic [ADDR_W-1:0] req_addr,
    output logic [EW-1:0]     elem
);
    localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(ELEM_BYTES);

    amode_e            mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= AM_UNIT;
            base_q <= '0;
            step_q <= '0;
            acc_q  <= '0;
            elem   <= '0;
        end else if (capture) begin
            mode_q <= amode_in;
            base_q <= base_in;
            step_q <= (amode_in == AM_STRIDE) ? stride_in : UNIT_STEP;
            acc_q  <= base_in;
            elem   <= '0;
        end else if (accept) begin
            acc_q <= acc_q + step_q;
            elem  <= elem + 1'b1;
        end
    end

    assign req_addr = (mode_q == AM_INDEX) ? (base_q + idx_value) : acc_q;

    a_r3_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && accept && (mode_q == AM_STRIDE)) ##1 valid |-> (req_addr == $past(req_addr) + step_q));
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && accept && (mode_q == AM_UNIT)) ##1 valid |-> (req_addr == $past(req_addr) + UNIT_STEP));
endmodule

// File: rtl/vls_elem_buf.sv
module vls_elem_buf #(
    parameter int MAX_VL = 64,
    parameter int ELEM_W = 64,
    parameter int EW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [MAX_VL-1:0] mask_in,
    input  logic [EW-1:0]     issue_elem,
    output logic              issue_mask,
    input  logic              rsp_fire,
    input  logic [ELEM_W-1:0] rsp_data,
    output logic [EW-1:0]     rsp_cnt,
    input  logic [EW-1:0]     rd_elem,
    output logic [ELEM_W-1:0] rd_data
);
    logic [MAX_VL-1:0] mask_q;
    logic [ELEM_W-1:0] mem [MAX_VL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rsp_cnt <= '0;
        end else if (capture) begin
            mask_q  <= mask_in;
            rsp_cnt <= '0;
        end else if (rsp_fire) begin
            rsp_cnt <= rsp_cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < MAX_VL; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rsp_fire && (rsp_cnt == EW'(g)) && mask_q[g])
                mem[g] <= rsp_data;
        end
    end

    assign issue_mask = mask_q[issue_elem];
    assign rd_data    = mem[rd_elem];
endmodule

// File: rtl/vls_sequencer.sv
module vls_sequencer
    import vls_pkg::*;
#(
    parameter int MAX_VL     = 64,
    parameter int ELEM_W     = 64,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mode,
    input  logic                  is_store,
    input  logic [ADDR_W-1:0]     base,
    input  logic [ADDR_W-1:0]     stride,
    input  logic [$clog2(MAX_VL)+1:0] vlen,
    input  logic [MAX_VL-1:0]     mask,
    input  logic [ADDR_W-1:0]     idx_value,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [ADDR_W-1:0]     req_addr,
    output logic                  req_write,
    output logic                  req_mask,
    output logic [$clog2(MAX_VL)-1:0] req_elem,
    input  logic                  rsp_valid,
    input  logic [ELEM_W-1:0]     rsp_data,
    input  logic [$clog2(MAX_VL)-1:0] rd_elem,
    output logic [ELEM_W-1:0]     rd_data,
    output logic                  busy,
    output logic                  done
);
    localparam int EW   = $clog2(MAX_VL);
    localparam int VL_W = EW + 2;

    seq_state_e      state;
    amode_e          amode;
    logic            capture, store_q, accept, last_issue, rsp_fire, last_rsp;
    logic [VL_W-1:0] vl_q;
    logic [EW-1:0]   rsp_cnt;

    assign amode      = mode[1] ? AM_INDEX : (mode[0] ? AM_STRIDE : AM_UNIT);
    assign accept     = req_valid && req_ready;
    assign last_issue = (VL_W'(req_elem) + VL_W'(1)) == vl_q;
    assign last_rsp   = (VL_W'(rsp_cnt) + VL_W'(1)) == vl_q;
    assign rsp_fire   = rsp_valid && !store_q &&
                        ((state == ST_ISSUE) || (state == ST_DRAIN));
    assign req_write  = store_q;

    vls_fsm #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .vlen(vlen), .accept(accept), .last_issue(last_issue),
        .rsp_fire(rsp_fire), .last_rsp(last_rsp), .capture(capture),
        .store_q(store_q), .vl_q(vl_q), .state(state),
        .req_valid(req_valid), .busy(busy), .done(done)
    );

    vls_addr_gen #(.ADDR_W(ADDR_W), .EW(EW), .ELEM_BYTES(ELEM_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n), .capture(capture), .amode_in(amode),
        .base_in(base), .stride_in(stride), .valid(req_valid),
        .accept(accept), .idx_value(idx_value), .req_addr(req_addr),
        .elem(req_elem)
    );

    vls_elem_buf #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W), .EW(EW)) u_buf (
        .clk(clk), .rst_n(rst_n), .capture(capture), .mask_in(mask),
        .issue_elem(req_elem), .issue_mask(req_mask), .rsp_fire(rsp_fire),
        .rsp_data(rsp_data), .rsp_cnt(rsp_cnt), .rd_elem(rd_elem),
        .rd_data(rd_data)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid && !done);
    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_elem));
    a_r5_elem_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) ##1 req_valid |-> (req_elem == EW'($past(req_elem) + 1'b1)));
    a_r6_elem_in_len: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (VL_W'(req_elem) < vl_q));
    a_r11_rsp_in_len: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |-> (VL_W'(rsp_cnt) < vl_q));
endmodule

// File: tb/sim_vls_sequencer.sv
module sim_vls_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 12;
    localparam int NC  = 6;

    localparam logic [1:0]  C_MODE  [NC] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0};
    localparam logic        C_ST    [NC] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [7:0]  C_VL    [NC] = '{8'd20, 8'd17, 8'd64, 8'd33, 8'd10, 8'd100};
    localparam logic [31:0] C_BASE  [NC] = '{32'h1000, 32'h2000, 32'h8000, 32'h4000, 32'h100, 32'hFFFF_FF00};
    localparam logic [31:0] C_STR   [NC] = '{32'h0, 32'h30, 32'hFFFF_FFF0, 32'h0, 32'h0, 32'h0};
    localparam logic [63:0] C_MASK  [NC] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555,
                                             64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_FFFF_FFFF_FFFF,
                                             64'h0000_0000_0000_02A5, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic        C_STALL [NC] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_store = 1'b0;
    logic [1:0] mode = '0;
    logic [31:0] base = '0, stride = '0, idx_value, req_addr;
    logic [7:0] vlen = '0;
    logic [63:0] mask = '0, rsp_data, rd_data;
    logic req_valid, req_ready = 1'b1, req_write, req_mask, rsp_valid, busy, done;
    logic [5:0] req_elem, rd_elem = '0;

    int total = 0, bad = 0, cyc = 0, stall_en = 0;
    int n_req, last_acc, done_cyc, done_cnt, start_cyc;
    logic [31:0] log_addr [128];
    logic        log_w [128], log_m [128];
    logic [5:0]  log_e [128];
    logic [63:0] shadow [64];
    logic        known [64];
    logic        pipe_v [LAT];
    logic [63:0] pipe_d [LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] idx_of(input logic [5:0] e);
        return (32'(e) * 32'd40) ^ (e[0] ? 32'h0001_0008 : 32'h8);
    endfunction
    function automatic logic [63:0] fdata(input logic [31:0] a);
        return {a ^ 32'hA5A5_5A5A, a};
    endfunction

    assign idx_value = idx_of(req_elem);
    assign rsp_valid = pipe_v[LAT-1];
    assign rsp_data  = pipe_d[LAT-1];

    vls_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_store(is_store),
        .base(base), .stride(stride), .vlen(vlen), .mask(mask), .idx_value(idx_value),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_mask(req_mask), .req_elem(req_elem),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_elem(rd_elem),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (req_valid && req_ready) begin
            if (n_req < 128) begin
                log_addr[n_req] = req_addr; log_w[n_req] = req_write;
                log_m[n_req] = req_mask;    log_e[n_req] = req_elem;
            end
            n_req = n_req + 1;
            last_acc = cyc;
        end
        if (done) begin done_cyc = cyc; done_cnt = done_cnt + 1; end
        if (start && !busy) start_cyc = cyc;
        pipe_v[0] <= req_valid && req_ready && !req_write;
        pipe_d[0] <= fdata(req_addr);
        for (int k = 1; k < LAT; k++) begin
            pipe_v[k] <= pipe_v[k-1];
            pipe_d[k] <= pipe_d[k-1];
        end
        req_ready <= !((stall_en != 0) && ((cyc % 3) == 1));
        cyc = cyc + 1;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] m, input logic st, input logic [7:0] vl,
                          input logic [31:0] b, input logic [31:0] s, input logic [63:0] mk);
        @(negedge clk);
        n_req = 0; done_cyc = -1; done_cnt = 0; start_cyc = -1;
        mode = m; is_store = st; vlen = vl; base = b; stride = s; mask = mk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_cyc < 0 && guard < 2000) begin @(negedge clk); guard++; end
        if (done_cyc < 0) chk(1'b0, "R5", "operation timeout", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_buffer(input string req);
        for (int i = 0; i < 64; i++) begin
            if (known[i]) begin
                rd_elem = 6'(i);
                #1;
                chk(rd_data == shadow[i], req, $sformatf("buffer entry %0d", i), rd_data, shadow[i]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < LAT; k++) begin pipe_v[k] = 1'b0; pipe_d[k] = '0; end
        for (int k = 0; k < 64; k++) begin known[k] = 1'b0; shadow[k] = '0; end
        n_req = 0; done_cnt = 0; done_cyc = -1; last_acc = 0; start_cyc = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1", "busy after reset", 64'(busy), 0);
        chk(!done, "R1", "done after reset", 64'(done), 0);
        chk(!req_valid, "R1", "req_valid after reset", 64'(req_valid), 0);

        for (int c = 0; c < NC; c++) begin
            int vl_exp;
            stall_en = C_STALL[c];
            vl_exp = (C_VL[c] > 8'd64) ? 64 : int'(C_VL[c]);
            launch(C_MODE[c], C_ST[c], C_VL[c], C_BASE[c], C_STR[c], C_MASK[c]);
            wait_done();
            // R5 / R6: element count, clamped to 64
            chk(n_req == vl_exp, "R6", $sformatf("case %0d request count", c), 64'(n_req), 64'(vl_exp));
            for (int i = 0; i < vl_exp && i < n_req; i++) begin
                logic [31:0] ea;
                string rq;
                if (C_MODE[c] == 2'd0) begin ea = C_BASE[c] + 32'(8 * i); rq = "R2"; end
                else if (C_MODE[c] == 2'd1) begin ea = C_BASE[c] + 32'(i) * C_STR[c]; rq = "R3"; end
                else begin ea = C_BASE[c] + idx_of(6'(i)); rq = "R4"; end
                chk(log_addr[i] == ea, rq, $sformatf("case %0d elem %0d address", c, i), 64'(log_addr[i]), 64'(ea));
                chk(log_e[i] == 6'(i), "R5", $sformatf("case %0d order %0d", c, i), 64'(log_e[i]), 64'(i));
                chk(log_m[i] == C_MASK[c][i], "R8", $sformatf("case %0d mask %0d", c, i), 64'(log_m[i]), 64'(C_MASK[c][i]));
                chk(log_w[i] == C_ST[c], C_ST[c] ? "R10" : "R11", "write flag", 64'(log_w[i]), 64'(C_ST[c]));
                if (!C_ST[c] && C_MASK[c][i]) begin shadow[i] = fdata(ea); known[i] = 1'b1; end
            end
            chk(done_cnt == 1, C_ST[c] ? "R10" : "R11", "done pulse count", 64'(done_cnt), 1);
            if (C_ST[c])
                chk(done_cyc == last_acc + 1, "R10", "store done timing", 64'(done_cyc), 64'(last_acc + 1));
            else begin
                chk(done_cyc == last_acc + LAT + 1, "R11", "load done timing", 64'(done_cyc), 64'(last_acc + LAT + 1));
                check_buffer(C_MASK[c] == '1 ? "R9" : "R8");
            end
        end
        stall_en = 0;

        // R7: zero length
        launch(2'd0, 1'b0, 8'd0, 32'h5000, 32'h0, '1);
        wait_done();
        chk(n_req == 0, "R7", "requests for zero length", 64'(n_req), 0);
        chk(done_cyc == start_cyc + 1, "R7", "done timing zero length", 64'(done_cyc), 64'(start_cyc + 1));
        check_buffer("R7");

        // R12: start while busy is ignored
        launch(2'd0, 1'b1, 8'd8, 32'h9000, 32'h0, '1);
        @(negedge clk);
        mode = 2'd1; vlen = 8'd40; base = 32'h0; stride = 32'h4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(n_req == 8, "R12", "request count with extra start", 64'(n_req), 8);
        chk(done_cnt == 1, "R12", "done pulses with extra start", 64'(done_cnt), 1);
        for (int i = 0; i < 8 && i < n_req; i++)
            chk(log_addr[i] == 32'h9000 + 32'(8 * i), "R12", $sformatf("address %0d", i),
                64'(log_addr[i]), 64'(32'h9000 + 32'(8 * i)));
        repeat (4) @(negedge clk);
        chk(!busy && n_req == 8, "R12", "idle after run", 64'(busy), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule